// File: doc/BRIEF.md
# Frame-Synchronised Chroma Offset Registers

This block holds the start offsets of the two chroma planes (U and V) used when the display path fetches planar 4:2:0 video. It also counts frames arriving from the video input port. Software programs it over a simple single-cycle register bus. Each offset has two copies. A bus write updates the pending copy. The active copy, which the fetch logic consumes, is loaded from the pending copy only when the display timing logic signals the start of a frame or interlaced field. The fetch side therefore never sees an offset change in the middle of a picture.

The frame counter is four bits wide and shares a register word with the U offset. It advances once for each rising edge of the asynchronous video-input vertical sync, after that sync has passed through a two-stage synchroniser. On a sync edge where the count has already reached the programmed limit, the counter returns to zero instead of advancing. Software can overwrite the count to realign the input and display sides.

Top module: `chroma_offset_regs`

## Requirements
- R1: After reset, both pending and both active offsets are zero, the frame count is zero, and every read returns zero.
- R2: A write to address 0x0 stores bus_wdata[27:0] as the pending U offset, with bits 2:0 forced to zero. A read of 0x0 returns {frame count in bits 31:28, pending U offset in bits 27:0}.
- R3: A write to address 0x4 stores bus_wdata[27:0] as the pending V offset, with bits 2:0 forced to zero. Data bits 31:28 of that write change nothing: they do not reach the frame count, and a read of 0x4 returns zero in bits 31:28.
- R4: u_active and v_active change only at the clock edge that samples frame_start high. They hold their values at every other edge.
- R5: At an edge that samples frame_start high, each active offset takes the pending value it had before that edge. A bus write in the same cycle reaches the active copy only at the next frame_start.
- R6: The frame count increases by one for each rising edge of vsync_in. The new value appears at the third clock edge that samples vsync_in high. A steady level or a falling edge does not change the count.
- R7: On a detected sync edge, if the count is greater than or equal to frame_limit, the count becomes 0 instead of increasing.
- R8: A write to address 0x0 loads the frame count from bus_wdata[31:28]. The write wins over a sync edge detected in the same cycle, and that edge is then lost.
- R9: Writes to any address other than 0x0 and 0x4 change no state, and reads of such addresses return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | ADDR_W (4) | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| vsync_in | input | 1 | Asynchronous vertical sync from the video input |
| frame_start | input | 1 | Frame or field start strobe from display timing |
| frame_limit | input | 4 | Count at which the frame counter clears on sync |
| u_active | output | 28 | U offset used by the fetch logic |
| v_active | output | 28 | V offset used by the fetch logic |
| frame_count | output | 4 | Current frame count |

## Verification
The bench targets the cycle where a bus write and a frame_start coincide. A design that forwards the new write data into the active copy would change the offset one frame too early. It also places sync edges at the limit, with limits of 0 and 15. A design that wraps only at the maximum count, or clears only on equality, would count past the limit. Other stimulus lands a count write on the same cycle as a detected sync edge, where wrong priority would leave the count at the sync-derived value. Directed latency checks catch a synchroniser that is one stage short or long. Writes to the V word and to unmapped addresses test for leakage into the count.

// File: rtl/chroma_offset_regs.sv
module chroma_offset_regs #(
  parameter int ADDR_W  = 4,
  parameter int OFF_W   = 28,
  parameter int CNT_W   = 4,
  parameter int ALIGN_W = 3,
  parameter logic [ADDR_W-1:0] U_ADDR = 'h0,
  parameter logic [ADDR_W-1:0] V_ADDR = 'h4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              vsync_in,
  input  logic              frame_start,
  input  logic [CNT_W-1:0]  frame_limit,
  output logic [OFF_W-1:0]  u_active,
  output logic [OFF_W-1:0]  v_active,
  output logic [CNT_W-1:0]  frame_count
);
  localparam int PAD_W = 32 - OFF_W - CNT_W;

  logic [OFF_W-1:0] u_pend, v_pend, wr_off;
  logic [2:0]       vs_sync;
  logic             vs_edge, wr_u, wr_v;

  assign wr_u    = bus_wr && (bus_addr == U_ADDR);
  assign wr_v    = bus_wr && (bus_addr == V_ADDR);
  assign wr_off  = {bus_wdata[OFF_W-1:ALIGN_W], {ALIGN_W{1'b0}}};
  assign vs_edge = vs_sync[1] & ~vs_sync[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vs_sync <= '0;
    end else begin
      vs_sync <= {vs_sync[1:0], vsync_in};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      u_pend <= '0;
      v_pend <= '0;
    end else begin
      if (wr_u) u_pend <= wr_off;
      if (wr_v) v_pend <= wr_off;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      u_active <= '0;
      v_active <= '0;
    end else if (frame_start) begin
      u_active <= u_pend;
      v_active <= v_pend;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_count <= '0;
    end else if (wr_u) begin
      frame_count <= bus_wdata[31 -: CNT_W];
    end else if (vs_edge) begin
      frame_count <= (frame_count >= frame_limit) ? '0 : frame_count + 1'b1;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == U_ADDR)      bus_rdata = {frame_count, {PAD_W{1'b0}}, u_pend};
    else if (bus_addr == V_ADDR) bus_rdata = {{(CNT_W+PAD_W){1'b0}}, v_pend};
  end
endmodule

// File: rtl/chroma_offset_regs_chk.sv
module chroma_offset_regs_chk #(
  parameter int ADDR_W = 4,
  parameter int OFF_W  = 28,
  parameter int CNT_W  = 4,
  parameter logic [ADDR_W-1:0] U_ADDR = 'h0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic              frame_start,
  input logic [CNT_W-1:0]  frame_limit,
  input logic [OFF_W-1:0]  u_active,
  input logic [OFF_W-1:0]  v_active,
  input logic [CNT_W-1:0]  frame_count,
  input logic              vs_edge
);
  logic cnt_wr;
  assign cnt_wr = bus_wr && (bus_addr == U_ADDR);

  p_active_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> ($stable(u_active) && $stable(v_active)));

  p_count_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_wr && vs_edge && frame_count < frame_limit) |=> frame_count == $past(frame_count) + 1'b1);

  p_count_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_wr && !vs_edge) |=> $stable(frame_count));

  p_edge_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    vs_edge |=> !vs_edge);

  p_count_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_wr && vs_edge && frame_count >= frame_limit) |=> frame_count == '0);

  p_sw_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> frame_count == $past(bus_wdata[31 -: CNT_W]));
endmodule

bind chroma_offset_regs chroma_offset_regs_chk #(
  .ADDR_W(ADDR_W), .OFF_W(OFF_W), .CNT_W(CNT_W), .U_ADDR(U_ADDR)
) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .frame_start(frame_start), .frame_limit(frame_limit),
  .u_active(u_active), .v_active(v_active), .frame_count(frame_count),
  .vs_edge(vs_edge)
);

// File: tb/chroma_offset_regs_tb_top.sv
module chroma_offset_regs_tb_top;
  logic        clk = 0, rst_n = 0;
  logic        bus_wr = 0, vsync_in = 0, frame_start = 0;
  logic [3:0]  bus_addr = 0, frame_limit = 4'hF;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic [27:0] u_active, v_active;
  logic [3:0]  frame_count;

  int vectors = 0, errors = 0;
  logic [27:0] m_upend, m_vpend, m_uact, m_vact;
  logic [3:0]  m_cnt;
  logic        s1, s2, s3;

  always #2.5 clk = ~clk;

  chroma_offset_regs dut_i (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_read(logic [3:0] a);
    if (a == 4'h0) return {m_cnt, m_upend};
    if (a == 4'h4) return {4'h0, m_vpend};
    return 32'h0;
  endfunction

  function automatic logic [27:0] align(logic [31:0] d);
    return {d[27:3], 3'b000};
  endfunction

  task automatic model_edge();
    logic edge_seen;
    edge_seen = s2 & ~s3;
    s3 = s2; s2 = s1; s1 = vsync_in;
    if (bus_wr && bus_addr == 4'h0) m_cnt = bus_wdata[31:28];
    else if (edge_seen) m_cnt = (m_cnt >= frame_limit) ? 4'h0 : m_cnt + 4'h1;
    if (frame_start) begin m_uact = m_upend; m_vact = m_vpend; end
    if (bus_wr && bus_addr == 4'h0) m_upend = align(bus_wdata);
    if (bus_wr && bus_addr == 4'h4) m_vpend = align(bus_wdata);
  endtask

  task automatic cyc();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk("R5 u_active", {4'h0, u_active}, {4'h0, m_uact});
    chk("R5 v_active", {4'h0, v_active}, {4'h0, m_vact});
    chk("R6 frame_count", {28'h0, frame_count}, {28'h0, m_cnt});
    chk("R2 bus_rdata", bus_rdata, exp_read(bus_addr));
  endtask

  task automatic idle_inputs();
    bus_wr = 0; frame_start = 0;
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d; cyc(); bus_wr = 0;
  endtask

  initial begin
    #20000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    m_upend = 0; m_vpend = 0; m_uact = 0; m_vact = 0; m_cnt = 0;
    s1 = 0; s2 = 0; s3 = 0;
    void'($urandom(32'h1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk("R1 reset rdata", bus_rdata, 32'h0);
    chk("R1 reset active", {u_active, frame_count}, 32'h0);
    chk("R1 reset v", {4'h0, v_active}, 32'h0);

    wr(4'h0, 32'h5123_4567);
    chk("R2 read U", bus_rdata, 32'h5123_4560);
    chk("R4 no early load", {4'h0, u_active}, 32'h0);

    wr(4'h4, 32'hA765_4327);
    chk("R3 read V", bus_rdata, 32'h0765_4320);
    bus_addr = 4'h0; #1;
    chk("R3 count untouched", {28'h0, frame_count}, 32'h5);

    frame_start = 1; bus_wr = 1; bus_addr = 4'h4; bus_wdata = 32'h0000_1000;
    cyc(); idle_inputs();
    chk("R5 old pending V", {4'h0, v_active}, 32'h0765_4320);
    chk("R5 U loaded", {4'h0, u_active}, 32'h0123_4560);
    frame_start = 1; cyc(); frame_start = 0;
    chk("R5 next boundary", {4'h0, v_active}, 32'h0000_1000);

    wr(4'h0, 32'h2000_0000);
    frame_limit = 4'hF;
    vsync_in = 1; cyc();
    chk("R6 latency 1", {28'h0, frame_count}, 32'h2);
    cyc();
    chk("R6 latency 2", {28'h0, frame_count}, 32'h2);
    cyc();
    chk("R6 latency 3", {28'h0, frame_count}, 32'h3);
    repeat (4) cyc();
    chk("R6 level holds", {28'h0, frame_count}, 32'h3);
    vsync_in = 0; repeat (4) cyc();
    chk("R6 fall no effect", {28'h0, frame_count}, 32'h3);

    frame_limit = 4'h3;
    vsync_in = 1; repeat (3) cyc(); vsync_in = 0; repeat (3) cyc();
    chk("R7 clear at limit", {28'h0, frame_count}, 32'h0);

    vsync_in = 1; repeat (2) cyc();
    bus_wr = 1; bus_addr = 4'h0; bus_wdata = 32'h9000_0008; cyc(); bus_wr = 0;
    chk("R8 write beats edge", {28'h0, frame_count}, 32'h9);
    vsync_in = 0; repeat (3) cyc();
    chk("R8 edge lost", {28'h0, frame_count}, 32'h9);

    wr(4'h8, 32'hFFFF_FFFF);
    chk("R9 unmapped read", bus_rdata, 32'h0);
    bus_addr = 4'h0; #1;
    chk("R9 U intact", bus_rdata, 32'h9000_0008);

    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      if (r < 6) vsync_in = ~vsync_in;
      frame_start = ($urandom_range(0, 19) == 0);
      bus_wr = ($urandom_range(0, 7) == 0);
      case ($urandom_range(0, 3))
        0: bus_addr = 4'h0;
        1: bus_addr = 4'h4;
        2: bus_addr = 4'($urandom);
        default: bus_addr = 4'h0;
      endcase
      bus_wdata = $urandom;
      if ($urandom_range(0, 199) == 0) frame_limit = 4'($urandom);
      if (i == 2000) frame_limit = 4'h0;
      if (i == 3000) frame_limit = 4'hF;
      cyc();
    end
    idle_inputs();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule